// File: doc/BRIEF.md
# Frame-Synced Serial Write Receiver

This block receives writes over a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. It is meant to sit in front of the register bank of a write-only peripheral. All three pins, and the chain-enable strap, are taken into the system clock domain through a synchronizer chain. The block then acts on falling serial-clock edges that occur while a frame is open. Each accepted edge shifts one data bit into a 16-bit shift register, most significant bit first. A finished word goes to the register bank on a parallel bus, together with a single-cycle valid strobe.

The block has two modes, picked by the chain-enable strap and latched when a frame opens. In standalone mode the word is delivered right after the sixteenth accepted edge. Later clocks in that frame are then ignored, and the input-buffer enable flag drops. In chain mode every clock is shifted, so the register passes data on to the next device through the serial output. When the frame strobe rises, the last sixteen bits received become the word. In both modes, a frame whose strobe rises before sixteen edges have been accepted is dropped. An abort pulse is raised instead. Each delivered word advances a wrapping frame counter.

Top module: `ser_frame_rx`

## Requirements
- R1: After reset, word_o is 0, word_vld_o, abort_o, buf_en_o, sdo_o and frame_cnt_o are all 0.
- R2: A falling edge on sync_n_i opens a frame, and buf_en_o is high while the frame is collecting bits.
- R3: In standalone mode (chain_en_i low at frame start) the first 16 data bits, sampled on falling sclk_i edges, form word_o with the first bit in bit 15. word_vld_o is high for exactly one cycle per delivered word.
- R4: In standalone mode, after the 16th accepted edge buf_en_o goes low and further sclk_i edges in the same frame leave the shift register (and so sdo_o) unchanged.
- R5: If sync_n_i rises before 16 edges have been accepted, no word is delivered, abort_o pulses once, and word_o and frame_cnt_o keep their values.
- R6: In chain mode (chain_en_i high at frame start) any number of edges of at least 16 is accepted. On the rising edge of sync_n_i, word_o takes the last 16 bits shifted in, the most recent bit in bit 0.
- R7: sdo_o always carries bit 15 of the shift register, so in chain mode it repeats each data bit 16 accepted edges later.
- R8: sdo_oe_o follows chain_en_i (after synchronization); when it is low the serial output is to be left floating.
- R9: frame_cnt_o advances by exactly one for each delivered word and by nothing otherwise, wrapping at 2^CNT_W.
- R10: Falling sclk_i edges while sync_n_i is high shift nothing and deliver nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_i | input | 1 | Active-low frame strobe |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge |
| din_i | input | 1 | Serial data input |
| chain_en_i | input | 1 | Chain-mode strap, also the serial output drive enable |
| word_o | output | WORD_W | Last delivered word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word_o |
| abort_o | output | 1 | One-cycle pulse for a dropped short frame |
| frame_cnt_o | output | CNT_W | Wrapping count of delivered words |
| buf_en_o | output | 1 | Input-buffer enable flag, high while bits are collected |
| sdo_o | output | 1 | Shift register bit 15, for chaining or readback |
| sdo_oe_o | output | 1 | Drive enable for sdo_o; low means tri-stated |

## Verification
Standalone frames of exactly sixteen bits use alternating, walking and all-ones patterns. These show whether bit order and edge selection are right. Longer standalone frames add trailing clocks with data that differs from the word, which would show up if those clocks were not ignored. Chain frames of sixteen and of twenty-four bits separate "first sixteen" from "last sixteen" capture and check the sixteen-edge delay on the serial output. Frames cut short at fifteen, ten and zero bits, clocks with the strobe high, and a run of 256 frames exercise the abort path, the idle gating and the counter wrap.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_SHIFT = 2'd1,
      FR_HOLD  = 2'd2
   } fr_state_e;

   localparam int PIN_N     = 4;
   localparam int PIN_SYNC  = 0;
   localparam int PIN_SCLK  = 1;
   localparam int PIN_DIN   = 2;
   localparam int PIN_CHAIN = 3;

   localparam logic [PIN_N-1:0] PIN_RST = 4'b0001;

endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
   parameter int                W       = 4,
   parameter int                STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);

   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ser_rx_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= RST_VAL;
               else        stage_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ser_rx_ctrl.sv
module ser_rx_ctrl
   import ser_rx_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n_s,
   input  logic              sclk_s,
   input  logic              chain_s,
   output logic              shift_en_o,
   output logic              take_head_o,
   output logic              take_tail_o,
   output logic              abort_o,
   output logic              buf_en_o,
   output logic [CNT_W-1:0]  frame_cnt_o
);

   localparam int              BCW  = $clog2(WORD_W + 1);
   localparam logic [BCW-1:0]  FULL = BCW'(WORD_W);
   localparam logic [BCW-1:0]  LAST = BCW'(WORD_W - 1);

   fr_state_e         state_q, state_nxt;
   logic [BCW-1:0]    bit_q, bit_nxt;
   logic              sync_n_d, sclk_d;
   logic              chain_q, chain_nxt;
   logic              abort_q, abort_set;
   logic [CNT_W-1:0]  cnt_q;
   logic              sync_fall, sync_rise, sclk_fall;
   logic              shift_en, take_head, take_tail;

   assign sync_fall = sync_n_d & ~sync_n_s;
   assign sync_rise = ~sync_n_d & sync_n_s;
   assign sclk_fall = sclk_d & ~sclk_s;

   always_comb begin
      state_nxt = state_q;
      bit_nxt   = bit_q;
      chain_nxt = chain_q;
      shift_en  = 1'b0;
      take_head = 1'b0;
      take_tail = 1'b0;
      abort_set = 1'b0;
      unique case (state_q)
         FR_IDLE: begin
            if (sync_fall) begin
               state_nxt = FR_SHIFT;
               bit_nxt   = '0;
               chain_nxt = chain_s;
            end
         end
         FR_SHIFT: begin
            if (sync_rise) begin
               state_nxt = FR_IDLE;
               if (chain_q && (bit_q == FULL)) take_tail = 1'b1;
               else                            abort_set = 1'b1;
            end else if (sclk_fall) begin
               shift_en = 1'b1;
               if (bit_q != FULL) bit_nxt = bit_q + 1'b1;
               if (!chain_q && (bit_q == LAST)) begin
                  take_head = 1'b1;
                  state_nxt = FR_HOLD;
               end
            end
         end
         FR_HOLD: begin
            if (sync_rise) state_nxt = FR_IDLE;
         end
         default: state_nxt = FR_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FR_IDLE;
         bit_q    <= '0;
         chain_q  <= 1'b0;
         sync_n_d <= 1'b1;
         sclk_d   <= 1'b0;
         abort_q  <= 1'b0;
         cnt_q    <= '0;
      end else begin
         state_q  <= state_nxt;
         bit_q    <= bit_nxt;
         chain_q  <= chain_nxt;
         sync_n_d <= sync_n_s;
         sclk_d   <= sclk_s;
         abort_q  <= abort_set;
         if (take_head || take_tail) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign shift_en_o  = shift_en;
   assign take_head_o = take_head;
   assign take_tail_o = take_tail;
   assign abort_o     = abort_q;
   assign buf_en_o    = (state_q == FR_SHIFT);
   assign frame_cnt_o = cnt_q;

endmodule

// File: rtl/ser_rx_shift.sv
module ser_rx_shift #(
   parameter int WORD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en_i,
   input  logic               din_s,
   input  logic               take_head_i,
   input  logic               take_tail_i,
   output logic [WORD_W-1:0]  word_o,
   output logic               word_vld_o,
   output logic               msb_o
);

   logic [WORD_W-1:0] sreg_q, sreg_nxt, word_q;
   logic              vld_q;

   assign sreg_nxt = {sreg_q[WORD_W-2:0], din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         if (shift_en_i)       sreg_q <= sreg_nxt;
         if (take_head_i)      word_q <= sreg_nxt;
         else if (take_tail_i) word_q <= sreg_q;
         vld_q <= take_head_i | take_tail_i;
      end
   end

   assign word_o     = word_q;
   assign word_vld_o = vld_q;
   assign msb_o      = sreg_q[WORD_W-1];

endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
   import ser_rx_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_n_i,
   input  logic               sclk_i,
   input  logic               din_i,
   input  logic               chain_en_i,
   output logic [WORD_W-1:0]  word_o,
   output logic               word_vld_o,
   output logic               abort_o,
   output logic [CNT_W-1:0]   frame_cnt_o,
   output logic               buf_en_o,
   output logic               sdo_o,
   output logic               sdo_oe_o
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("ser_frame_rx: WORD_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ser_frame_rx: CNT_W must be at least 1");
      end
   endgenerate

   logic [PIN_N-1:0] pins_raw, pins_s;
   logic             shift_en, take_head, take_tail;

   always_comb begin
      pins_raw            = '0;
      pins_raw[PIN_SYNC]  = sync_n_i;
      pins_raw[PIN_SCLK]  = sclk_i;
      pins_raw[PIN_DIN]   = din_i;
      pins_raw[PIN_CHAIN] = chain_en_i;
   end

   ser_rx_sync #(
      .W       (PIN_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   ser_rx_ctrl #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_n_s    (pins_s[PIN_SYNC]),
      .sclk_s      (pins_s[PIN_SCLK]),
      .chain_s     (pins_s[PIN_CHAIN]),
      .shift_en_o  (shift_en),
      .take_head_o (take_head),
      .take_tail_o (take_tail),
      .abort_o     (abort_o),
      .buf_en_o    (buf_en_o),
      .frame_cnt_o (frame_cnt_o)
   );

   ser_rx_shift #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .shift_en_i  (shift_en),
      .din_s       (pins_s[PIN_DIN]),
      .take_head_i (take_head),
      .take_tail_i (take_tail),
      .word_o      (word_o),
      .word_vld_o  (word_vld_o),
      .msb_o       (sdo_o)
   );

   assign sdo_oe_o = pins_s[PIN_CHAIN];

endmodule

// File: rtl/ser_frame_rx_chk.sv
module ser_frame_rx_chk #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [WORD_W-1:0]  word_o,
   input logic               word_vld_o,
   input logic               abort_o,
   input logic [CNT_W-1:0]   frame_cnt_o,
   input logic               buf_en_o,
   input logic               sdo_o
);

   p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);

   p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld_o |-> $stable(word_o));

   p_abort_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !word_vld_o);

   p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |-> (frame_cnt_o == CNT_W'($past(frame_cnt_o) + 1'b1)));

   p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld_o |-> $stable(frame_cnt_o));

   p_sdo_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_en_o |=> $stable(sdo_o));

endmodule

bind ser_frame_rx ser_frame_rx_chk #(
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .word_o      (word_o),
   .word_vld_o  (word_vld_o),
   .abort_o     (abort_o),
   .frame_cnt_o (frame_cnt_o),
   .buf_en_o    (buf_en_o),
   .sdo_o       (sdo_o)
);

// File: tb/test_ser_frame_rx.sv
`timescale 1ns/1ps
module test_ser_frame_rx;

   localparam int WORD_W = 16;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sync_n = 1'b1;
   logic              sclk = 1'b0;
   logic              din = 1'b0;
   logic              chain_en = 1'b0;
   logic [WORD_W-1:0] word;
   logic              word_vld, abort, buf_en, sdo, sdo_oe;
   logic [CNT_W-1:0]  frame_cnt;

   int n_chk = 0;
   int n_fail = 0;
   int exp_aborts = 0;
   int seen_aborts = 0;
   logic [CNT_W-1:0]  exp_cnt = '0;
   logic [WORD_W-1:0] m_sr = '0;
   logic [WORD_W-1:0] last_word = '0;
   logic [WORD_W-1:0] exp_q [$];

   always #2.5 clk = ~clk;

   ser_frame_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_ser_frame_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_n_i    (sync_n),
      .sclk_i      (sclk),
      .din_i       (din),
      .chain_en_i  (chain_en),
      .word_o      (word),
      .word_vld_o  (word_vld),
      .abort_o     (abort),
      .frame_cnt_o (frame_cnt),
      .buf_en_o    (buf_en),
      .sdo_o       (sdo),
      .sdo_oe_o    (sdo_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: scoreboard pop on every delivered word
   always @(negedge clk) begin
      if (rst_n) begin
         if (abort) seen_aborts++;
         if (word_vld) begin
            if (exp_q.size() == 0) begin
               check("R5/R10 unexpected word", {16'h0, word}, 32'hFFFF_FFFF);
            end else begin
               logic [WORD_W-1:0] e;
               e = exp_q.pop_front();
               check("R3/R6 word", {16'h0, word}, {16'h0, e});
               last_word = e;
            end
         end
      end
   end

   task automatic run_frame(input logic [31:0] pat, input int n, input bit chain);
      logic [WORD_W-1:0] head;
      head = '0;
      chain_en = chain;
      repeat (4) @(negedge clk);
      sync_n = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 buf_en open", {31'h0, buf_en}, 32'h1);
      for (int i = 0; i < n; i++) begin
         logic b;
         b = pat[n-1-i];
         din = b;
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         if (chain || i < WORD_W) m_sr = {m_sr[WORD_W-2:0], b};
         if (!chain && i == WORD_W-1) begin
            head = m_sr;
            exp_q.push_back(head);
            exp_cnt++;
         end
         repeat (4) @(negedge clk);
         check("R7 sdo bit15", {31'h0, sdo}, {31'h0, m_sr[WORD_W-1]});
         if (!chain && i == WORD_W-1)
            check("R4 buf_en low after word", {31'h0, buf_en}, 32'h0);
         if (!chain && i > WORD_W-1)
            check("R4 extra clock ignored", {31'h0, sdo}, {31'h0, m_sr[WORD_W-1]});
      end
      if (n >= WORD_W) begin
         if (chain) begin
            exp_q.push_back(m_sr);
            exp_cnt++;
         end
      end else begin
         exp_aborts++;
      end
      sync_n = 1'b1;
      repeat (24) @(negedge clk);
      check("R9 frame count", {24'h0, frame_cnt}, {24'h0, exp_cnt});
      check("R5 abort count", seen_aborts, exp_aborts);
      check("R5 word retained", {16'h0, word}, {16'h0, last_word});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check("watchdog", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R1 word", {16'h0, word}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 word", {16'h0, word}, 32'h0);
      check("R1 vld/abort/buf_en/sdo", {28'h0, word_vld, abort, buf_en, sdo}, 32'h0);
      check("R1 frame count", {24'h0, frame_cnt}, 32'h0);

      // R8: output drive enable follows the strap
      chain_en = 1'b1; repeat (4) @(negedge clk);
      check("R8 sdo_oe high", {31'h0, sdo_oe}, 32'h1);
      chain_en = 1'b0; repeat (4) @(negedge clk);
      check("R8 sdo_oe low", {31'h0, sdo_oe}, 32'h0);

      // R3: standalone 16-bit patterns
      run_frame(32'h0000_A5C3, 16, 1'b0);
      run_frame(32'h0000_8001, 16, 1'b0);
      run_frame(32'h0000_FFFF, 16, 1'b0);
      // R4: trailing clocks with different data
      run_frame(32'h000A_BCD5, 20, 1'b0);
      // R5: short frames
      run_frame(32'h0000_7FFF, 15, 1'b0);
      run_frame(32'h0000_0155, 10, 1'b1);
      run_frame(32'h0000_0000, 0, 1'b0);
      // R6: chain frames
      run_frame(32'h0000_3C96, 16, 1'b1);
      run_frame(32'h00F0_1E2D, 24, 1'b1);
      chain_en = 1'b1; repeat (4) @(negedge clk);
      check("R8 sdo_oe chain", {31'h0, sdo_oe}, 32'h1);

      // R10: clocks with the strobe high
      for (int k = 0; k < 5; k++) begin
         din = ~din;
         sclk = 1'b1; repeat (4) @(negedge clk);
         sclk = 1'b0; repeat (4) @(negedge clk);
      end
      check("R10 sdo unchanged", {31'h0, sdo}, {31'h0, m_sr[WORD_W-1]});
      check("R10 no delivery", {24'h0, frame_cnt}, {24'h0, exp_cnt});
      check("R10 word unchanged", {16'h0, word}, {16'h0, last_word});

      // R9: counter wrap
      for (int k = 0; k < 256; k++)
         run_frame(32'(k * 16'h0123), 16, 1'b0);

      repeat (10) @(negedge clk);
      check("R3 scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule